// File: doc/BRIEF.md
# Control-Flow-Integrity CSR Access Gate

This block rules on every attempt by a CSR instruction to touch one of the two control-flow-integrity registers: the landing-pad label register or the shadow-stack-pointer register. Its inputs are the privilege level of the requester, the virtualization bit, the machine-level and hypervisor-level CFI enables, and the forward-edge and backward-edge user enables. The user enables come from both the machine status register and the virtual-supervisor status register. It returns one of three outcomes: the access proceeds, it raises an illegal-instruction exception, or it raises a virtual-instruction exception.

The outcome is registered. A request presented in one cycle yields a one-hot verdict with a valid flag in the next cycle, so the block sits as one pipeline stage beside the CSR decode path. The checks are applied in a fixed order. A machine-level requester always passes. Next, the privilege encoding itself is checked, then the machine enable, then the hypervisor enable for virtualized requesters, and last the user enable that belongs to the selected register.

Top module: `cfi_csr_acc_chk`

## Requirements
- R1: While reset is high, and in the cycle after it, `vld_q`, `allow_q`, `illegal_q` and `virt_q` are all 0.
- R2: A request with `req_valid`=1 in cycle n gives `vld_q`=1 in cycle n+1. A cycle with `req_valid`=0 gives `vld_q`, `allow_q`, `illegal_q` and `virt_q` all 0 in the following cycle.
- R3: Whenever `vld_q`=1, exactly one of `allow_q`, `illegal_q` and `virt_q` is 1.
- R4: Privilege code 3 (machine) is always allowed, whatever the enables, `virt` or `csr_sel` are.
- R5: Privilege code 2 (reserved) always gives illegal-instruction.
- R6: For privilege code 0 (user) or 1 (supervisor) with `m_cfi_en`=0, the verdict is illegal-instruction, whatever `virt` is.
- R7: For privilege code 0 or 1 with `m_cfi_en`=1, `virt`=1 and `h_cfi_en`=0, the verdict is virtual-instruction.
- R8: For privilege code 0 with `virt`=0 and `m_cfi_en`=1, the verdict is illegal-instruction when the selected enable is 0 and allow when it is 1. With `csr_sel`=0 (label register) the selected enable is `ms_fwd_en`; with `csr_sel`=1 (shadow-stack pointer) it is `ms_bwd_en`. The `vs_*` enables have no effect here.
- R9: For privilege code 0 with `virt`=1 and both `m_cfi_en` and `h_cfi_en` at 1, the verdict is illegal-instruction when `vs_fwd_en` (for `csr_sel`=0) or `vs_bwd_en` (for `csr_sel`=1) is 0, and allow otherwise. The `ms_*` enables have no effect here.
- R10: For privilege code 1, the verdict is allow once the machine enable passes and, when `virt`=1, the hypervisor enable passes. The four user enables have no effect here.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A CSR access is being checked this cycle |
| priv | input | 2 | Requester privilege: 0 user, 1 supervisor, 2 reserved, 3 machine |
| virt | input | 1 | Virtualization bit of the requester |
| csr_sel | input | 1 | 0 selects the label register, 1 the shadow-stack pointer |
| m_cfi_en | input | 1 | Machine-level CFI enable |
| h_cfi_en | input | 1 | Hypervisor-level CFI enable |
| ms_fwd_en | input | 1 | User forward-edge enable, machine status copy |
| ms_bwd_en | input | 1 | User backward-edge enable, machine status copy |
| vs_fwd_en | input | 1 | User forward-edge enable, virtual-supervisor copy |
| vs_bwd_en | input | 1 | User backward-edge enable, virtual-supervisor copy |
| vld_q | output | 1 | Verdict valid, one cycle after the request |
| allow_q | output | 1 | Access may proceed |
| illegal_q | output | 1 | Raise illegal-instruction |
| virt_q | output | 1 | Raise virtual-instruction |

## Verification
The assertions assume that every input holds a defined value at each rising edge while reset is low. They also assume that a request is judged only on the input values sampled at its own edge, so each verdict property refers back to the previous cycle's inputs alone. The stimulus changes all inputs only on the falling edge. It sweeps all 1024 combinations of privilege, `virt`, `csr_sel` and the six enables, and after each group of eight requests it inserts an idle cycle. The reserved privilege code and the machine code with `virt`=1 are therefore covered along with the legal encodings.

// File: rtl/cfi_acc_pkg.sv
package cfi_acc_pkg;
  localparam int PRIV_W = 2;
  localparam logic [PRIV_W-1:0] PRIV_USR = 2'd0;
  localparam logic [PRIV_W-1:0] PRIV_SUP = 2'd1;
  localparam logic [PRIV_W-1:0] PRIV_RSV = 2'd2;
  localparam logic [PRIV_W-1:0] PRIV_MCH = 2'd3;

  localparam logic SEL_LABEL = 1'b0;
  localparam logic SEL_SSP   = 1'b1;

  typedef enum logic [1:0] {
    VERD_NONE    = 2'd0,
    VERD_ALLOW   = 2'd1,
    VERD_ILLEGAL = 2'd2,
    VERD_VIRT    = 2'd3
  } verdict_e;
endpackage

// File: rtl/cfi_env_gate.sv
module cfi_env_gate
  import cfi_acc_pkg::*;
(
  input  logic [PRIV_W-1:0] priv,
  input  logic              virt,
  input  logic              m_cfi_en,
  input  logic              h_cfi_en,
  output logic              is_mach,
  output logic              is_rsv,
  output logic              is_user,
  output logic              m_block,
  output logic              h_block
);
  always_comb begin
    is_mach = (priv == PRIV_MCH);
    is_rsv  = (priv == PRIV_RSV);
    is_user = (priv == PRIV_USR);
    m_block = !m_cfi_en;
    h_block = virt && !h_cfi_en;
  end
endmodule

// File: rtl/cfi_user_gate.sv
module cfi_user_gate
  import cfi_acc_pkg::*;
(
  input  logic csr_sel,
  input  logic virt,
  input  logic ms_fwd_en,
  input  logic ms_bwd_en,
  input  logic vs_fwd_en,
  input  logic vs_bwd_en,
  output logic user_ok
);
  logic fwd_en, bwd_en;

  always_comb begin
    fwd_en  = virt ? vs_fwd_en : ms_fwd_en;
    bwd_en  = virt ? vs_bwd_en : ms_bwd_en;
    user_ok = (csr_sel == SEL_SSP) ? bwd_en : fwd_en;
  end
endmodule

// File: rtl/cfi_verdict_reg.sv
module cfi_verdict_reg
  import cfi_acc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  verdict_e verdict_d,
  output logic     vld_q,
  output logic     allow_q,
  output logic     illegal_q,
  output logic     virt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q     <= 1'b0;
      allow_q   <= 1'b0;
      illegal_q <= 1'b0;
      virt_q    <= 1'b0;
    end else begin
      vld_q     <= (verdict_d != VERD_NONE);
      allow_q   <= (verdict_d == VERD_ALLOW);
      illegal_q <= (verdict_d == VERD_ILLEGAL);
      virt_q    <= (verdict_d == VERD_VIRT);
    end
  end
endmodule

// File: rtl/cfi_csr_acc_chk.sv
module cfi_csr_acc_chk
  import cfi_acc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [PRIV_W-1:0] priv,
  input  logic              virt,
  input  logic              csr_sel,
  input  logic              m_cfi_en,
  input  logic              h_cfi_en,
  input  logic              ms_fwd_en,
  input  logic              ms_bwd_en,
  input  logic              vs_fwd_en,
  input  logic              vs_bwd_en,
  output logic              vld_q,
  output logic              allow_q,
  output logic              illegal_q,
  output logic              virt_q
);
  logic is_mach, is_rsv, is_user, m_block, h_block, user_ok;
  verdict_e verdict_d;

  cfi_env_gate u_env (
    .priv     (priv),
    .virt     (virt),
    .m_cfi_en (m_cfi_en),
    .h_cfi_en (h_cfi_en),
    .is_mach  (is_mach),
    .is_rsv   (is_rsv),
    .is_user  (is_user),
    .m_block  (m_block),
    .h_block  (h_block)
  );

  cfi_user_gate u_user (
    .csr_sel   (csr_sel),
    .virt      (virt),
    .ms_fwd_en (ms_fwd_en),
    .ms_bwd_en (ms_bwd_en),
    .vs_fwd_en (vs_fwd_en),
    .vs_bwd_en (vs_bwd_en),
    .user_ok   (user_ok)
  );

  // Priority: machine, reserved code, machine enable, hypervisor enable, user enable
  always_comb begin
    if (!req_valid)                verdict_d = VERD_NONE;
    else if (is_mach)              verdict_d = VERD_ALLOW;
    else if (is_rsv)               verdict_d = VERD_ILLEGAL;
    else if (m_block)              verdict_d = VERD_ILLEGAL;
    else if (h_block)              verdict_d = VERD_VIRT;
    else if (is_user && !user_ok)  verdict_d = VERD_ILLEGAL;
    else                           verdict_d = VERD_ALLOW;
  end

  cfi_verdict_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .verdict_d (verdict_d),
    .vld_q     (vld_q),
    .allow_q   (allow_q),
    .illegal_q (illegal_q),
    .virt_q    (virt_q)
  );
endmodule

// File: rtl/cfi_csr_acc_sva.sv
module cfi_csr_acc_sva (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [1:0] priv,
  input logic       virt,
  input logic       csr_sel,
  input logic       m_cfi_en,
  input logic       h_cfi_en,
  input logic       ms_fwd_en,
  input logic       ms_bwd_en,
  input logic       vld_q,
  input logic       allow_q,
  input logic       illegal_q,
  input logic       virt_q
);
  // R2
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> vld_q);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !vld_q && !allow_q && !illegal_q && !virt_q);

  // R3
  one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> $countones({allow_q, illegal_q, virt_q}) == 1);

  // R4
  mach_allow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && priv == 2'd3 |=> allow_q);

  // R5
  rsv_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && priv == 2'd2 |=> illegal_q);

  // R6
  menable_off_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !priv[1] && !m_cfi_en |=> illegal_q);

  // R7
  henable_off_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !priv[1] && m_cfi_en && virt && !h_cfi_en |=> virt_q);

  // R8
  user_ssp_off_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && priv == 2'd0 && !virt && m_cfi_en && csr_sel && !ms_bwd_en |=> illegal_q);

  // R8
  user_label_off_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && priv == 2'd0 && !virt && m_cfi_en && !csr_sel && !ms_fwd_en |=> illegal_q);

  // R10
  sup_allow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && priv == 2'd1 && m_cfi_en && (!virt || h_cfi_en) |=> allow_q);
endmodule

bind cfi_csr_acc_chk cfi_csr_acc_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .priv      (priv),
  .virt      (virt),
  .csr_sel   (csr_sel),
  .m_cfi_en  (m_cfi_en),
  .h_cfi_en  (h_cfi_en),
  .ms_fwd_en (ms_fwd_en),
  .ms_bwd_en (ms_bwd_en),
  .vld_q     (vld_q),
  .allow_q   (allow_q),
  .illegal_q (illegal_q),
  .virt_q    (virt_q)
);

// File: tb/test_cfi_csr_acc_chk.sv
module test_cfi_csr_acc_chk;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] priv = 2'd0;
  logic virt = 1'b0, csr_sel = 1'b0;
  logic m_cfi_en = 1'b0, h_cfi_en = 1'b0;
  logic ms_fwd_en = 1'b0, ms_bwd_en = 1'b0, vs_fwd_en = 1'b0, vs_bwd_en = 1'b0;
  logic vld_q, allow_q, illegal_q, virt_q;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfi_csr_acc_chk i_cfi_csr_acc_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .priv(priv), .virt(virt),
    .csr_sel(csr_sel), .m_cfi_en(m_cfi_en), .h_cfi_en(h_cfi_en),
    .ms_fwd_en(ms_fwd_en), .ms_bwd_en(ms_bwd_en),
    .vs_fwd_en(vs_fwd_en), .vs_bwd_en(vs_bwd_en),
    .vld_q(vld_q), .allow_q(allow_q), .illegal_q(illegal_q), .virt_q(virt_q)
  );

  // expected {vld, allow, illegal, virt} and the requirement it rests on
  logic [3:0] exp_q[$];
  string      tag_q[$];

  task automatic model(input bit rv, input int p, input bit v, input bit s,
                       input bit me, input bit he, input bit mf, input bit mb,
                       input bit vf, input bit vb);
    logic [3:0] e;
    string t;
    bit en;
    if (!rv) begin e = 4'b0000; t = "R2"; end
    else if (p == 3) begin e = 4'b1100; t = "R4"; end
    else if (p == 2) begin e = 4'b1010; t = "R5"; end
    else if (!me) begin e = 4'b1010; t = "R6"; end
    else if (v && !he) begin e = 4'b1001; t = "R7"; end
    else if (p == 1) begin e = 4'b1100; t = "R10"; end
    else begin
      if (v) en = s ? vb : vf; else en = s ? mb : mf;
      e = en ? 4'b1100 : 4'b1010;
      t = v ? "R9" : "R8";
    end
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic compare();
    logic [3:0] got, e;
    string t;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    got = {vld_q, allow_q, illegal_q, virt_q};
    n_vec++;
    if (got !== e) begin
      n_bad++;
      $display("FAIL %s: {vld,allow,illegal,virt} got %b expected %b", t, got, e);
    end
    if (vld_q && $countones({allow_q, illegal_q, virt_q}) != 1) begin
      n_bad++;
      $display("FAIL R3: verdict flags got %b expected one-hot", got[2:0]);
    end
  endtask

  initial begin
    // R1: reset state, during and right after reset
    repeat (2) @(negedge clk);
    n_vec++;
    if ({vld_q, allow_q, illegal_q, virt_q} !== 4'b0000) begin
      n_bad++;
      $display("FAIL R1: outputs got %b expected 0000", {vld_q, allow_q, illegal_q, virt_q});
    end
    req_valid = 1'b1; priv = 2'd3;
    @(negedge clk);
    rst = 1'b0;
    req_valid = 1'b0;
    n_vec++;
    if ({vld_q, allow_q, illegal_q, virt_q} !== 4'b0000) begin
      n_bad++;
      $display("FAIL R1: outputs got %b expected 0000", {vld_q, allow_q, illegal_q, virt_q});
    end
    model(1'b0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      compare();
      req_valid = 1'b1;
      priv      = i[1:0];
      virt      = i[2];
      csr_sel   = i[3];
      m_cfi_en  = i[4];
      h_cfi_en  = i[5];
      ms_fwd_en = i[6];
      ms_bwd_en = i[7];
      vs_fwd_en = i[8];
      vs_bwd_en = i[9];
      model(1'b1, int'(i[1:0]), i[2], i[3], i[4], i[5], i[6], i[7], i[8], i[9]);
      if (i % 8 == 7) begin
        @(negedge clk);
        compare();
        req_valid = 1'b0;
        priv = ~priv;
        m_cfi_en = ~m_cfi_en;
        model(1'b0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      end
    end
    @(negedge clk);
    compare();
    req_valid = 1'b0;
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL R2: watchdog expired, got running expected finished");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule